// File: doc/BRIEF.md
# Register-Mapped Multiply and Divide Helper

This block is a small arithmetic coprocessor that sits on a byte-wide register bus. Software loads an 8-bit multiplicand and then writes the multiplier. That write starts an unsigned multiply, and the 16-bit product is ready on the next cycle. For division, software loads a 16-bit dividend one byte at a time and then writes an 8-bit divisor. That write starts an unsigned restoring divide, which runs for one cycle per dividend bit while a busy output is high.

The results sit in two 16-bit registers, and each is read one byte at a time. One register holds the quotient. The other is shared: it holds the last product after a multiply, and the remainder after a divide. Dividing by zero takes no iterations. It gives an all-ones quotient, and the dividend passes through as the remainder.

The operand registers keep their values after each operation, so a multiplicand or dividend can serve several operations in a row. The reset values match the state left by a multiply and a divide of all-ones operands.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, the quotient reads 0x0101 and product/remainder reads 0xFE01, busy is low, the multiplicand holds 0xFF and the dividend holds 0xFFFF.
- R2: A write to offset 0x03 with value b makes product/remainder equal multiplicand*b (unsigned, 16 bits) from the next cycle, leaving the quotient unchanged.
- R3: A nonzero write to offset 0x06 raises busy from the next cycle. Busy stays high for exactly 16 cycles. When it falls, the quotient holds dividend/divisor and product/remainder holds dividend%divisor, zero-extended.
- R4: A zero write to offset 0x06 keeps busy low. From the next cycle the quotient is 0xFFFF and product/remainder equals the dividend.
- R5: Reads are combinational on the current address: 0x14 gives the quotient low byte, 0x15 the quotient high byte, 0x16 the product/remainder low byte and 0x17 its high byte. Every other offset, the write-only operand offsets included, reads 0x00.
- R6: Offset 0x02 loads the multiplicand; offsets 0x04 and 0x05 load the dividend's low and high bytes. These registers are not changed by operations and can be reused for later operations.
- R7: A nonzero divisor write while busy restarts the divide using the dividend held at that moment and the new divisor. Busy then stays high for 16 cycles counted from the restart.
- R8: A multiply write while busy abandons the divide. Busy is low from the next cycle, the product is stored, and the quotient keeps its earlier value.
- R9: While a divide runs, the readable results do not change and writes to the dividend do not affect the running divide; the new dividend is used by the next divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 5 | Register offset for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the offset on addr |
| busy | output | 1 | High while an iterative divide is running |

## Verification
The checker assumes that addr and wr_data are valid whenever wr_en is high, and that at most one register write arrives per cycle. It also assumes that reset is held for at least one clock before the first write. The bench drives every input on the falling edge, one write or read per cycle. It holds reset for several cycles and keeps wr_en low except during an intended write. As a result, every divisor, multiplier or dividend write seen by the checker is a deliberate operation with known operands.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int ADDR_W = 5;

    // Write offsets
    localparam logic [ADDR_W-1:0] OFS_MCAND  = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_MPLR   = 5'h03;
    localparam logic [ADDR_W-1:0] OFS_DVD_LO = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DVD_HI = 5'h05;
    localparam logic [ADDR_W-1:0] OFS_DVSR   = 5'h06;
    // Read offsets
    localparam logic [ADDR_W-1:0] OFS_QUO_LO = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_QUO_HI = 5'h15;
    localparam logic [ADDR_W-1:0] OFS_PR_LO  = 5'h16;
    localparam logic [ADDR_W-1:0] OFS_PR_HI  = 5'h17;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_MUL,
        OP_DIV,
        OP_DIVZ
    } op_e;

    typedef struct packed {
        op_e  op;
        logic ld_mcand;
        logic ld_dvd_lo;
        logic ld_dvd_hi;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(
        input logic              en,
        input logic [ADDR_W-1:0] a,
        input logic              data_zero
    );
        wr_dec_t d;
        d = '0;
        d.op = OP_NONE;
        if (en) begin
            case (a)
                OFS_MCAND:  d.ld_mcand  = 1'b1;
                OFS_MPLR:   d.op        = OP_MUL;
                OFS_DVD_LO: d.ld_dvd_lo = 1'b1;
                OFS_DVD_HI: d.ld_dvd_hi = 1'b1;
                OFS_DVSR:   d.op        = data_zero ? OP_DIVZ : OP_DIV;
                default:    d.op        = OP_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0]   mcand,
    input  logic [OP_W-1:0]   mplr,
    output logic [2*OP_W-1:0] prod
);
    localparam int RES_W = 2 * OP_W;

    logic [RES_W-1:0] pp [OP_W];

    // One shifted partial product per multiplier bit
    for (genvar i = 0; i < OP_W; i++) begin : g_pp
        assign pp[i] = mplr[i] ? (RES_W'(mcand) << i) : '0;
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < OP_W; i++) begin
            prod = prod + pp[i];
        end
    end

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
    parameter int OP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [2*OP_W-1:0] dividend,
    input  logic [OP_W-1:0]   divisor,
    output logic              busy,
    output logic              fin,
    output logic [2*OP_W-1:0] quo,
    output logic [OP_W-1:0]   rem
);
    localparam int RES_W = 2 * OP_W;
    localparam int CNT_W = $clog2(RES_W + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [OP_W-1:0]  rem_q;
    logic [RES_W-1:0] quo_q;
    logic [OP_W-1:0]  dvs_q;

    logic [OP_W:0]    part;
    logic             ge;
    logic [OP_W-1:0]  rem_nx;
    logic [RES_W-1:0] quo_nx;

    // One restoring step: shift in the next dividend bit, trial subtract
    always_comb begin
        part   = {rem_q, quo_q[RES_W-1]};
        ge     = part >= {1'b0, dvs_q};
        rem_nx = ge ? OP_W'(part - {1'b0, dvs_q}) : part[OP_W-1:0];
        quo_nx = {quo_q[RES_W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(RES_W);
            rem_q  <= '0;
            quo_q  <= dividend;
            dvs_q  <= divisor;
        end else if (abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign fin  = busy_q && (cnt_q == CNT_W'(1)) && !start && !abort;
    assign quo  = quo_nx;
    assign rem  = rem_nx;

endmodule

// File: rtl/muldiv_rdmux.sv
module muldiv_rdmux
    import muldiv_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2*OP_W-1:0] quo,
    input  logic [2*OP_W-1:0] pr,
    output logic [OP_W-1:0]   rd_data
);
    localparam int RES_W = 2 * OP_W;

    always_comb begin
        case (addr)
            OFS_QUO_LO: rd_data = quo[OP_W-1:0];
            OFS_QUO_HI: rd_data = quo[RES_W-1:OP_W];
            OFS_PR_LO:  rd_data = pr[OP_W-1:0];
            OFS_PR_HI:  rd_data = pr[RES_W-1:OP_W];
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OP_W-1:0]   wr_data,
    output logic [OP_W-1:0]   rd_data,
    output logic              busy
);
    localparam int RES_W = 2 * OP_W;
    localparam logic [OP_W-1:0]  RST_MCAND = '1;
    localparam logic [RES_W-1:0] RST_DVD   = '1;
    localparam logic [RES_W-1:0] RST_PR    = RES_W'(RST_MCAND) * RES_W'(RST_MCAND);
    localparam logic [RES_W-1:0] RST_QUO   = RST_DVD / RES_W'(RST_MCAND);

    wr_dec_t          dec;
    logic [OP_W-1:0]  mcand_q;
    logic [RES_W-1:0] dvd_q;
    logic [RES_W-1:0] quo_q;
    logic [RES_W-1:0] pr_q;
    logic [RES_W-1:0] prod;
    logic             div_start;
    logic             div_abort;
    logic             div_fin;
    logic [RES_W-1:0] div_quo;
    logic [OP_W-1:0]  div_rem;

    assign dec       = decode_wr(wr_en, addr, wr_data == '0);
    assign div_start = (dec.op == OP_DIV);
    assign div_abort = (dec.op == OP_MUL) || (dec.op == OP_DIVZ);

    muldiv_mul #(.OP_W(OP_W)) mul_i (
        .mcand (mcand_q),
        .mplr  (wr_data),
        .prod  (prod)
    );

    muldiv_div #(.OP_W(OP_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .abort    (div_abort),
        .dividend (dvd_q),
        .divisor  (wr_data),
        .busy     (busy),
        .fin      (div_fin),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    // Operand registers: only their own writes change them
    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= RST_MCAND;
            dvd_q   <= RST_DVD;
        end else begin
            if (dec.ld_mcand)  mcand_q             <= wr_data;
            if (dec.ld_dvd_lo) dvd_q[OP_W-1:0]     <= wr_data;
            if (dec.ld_dvd_hi) dvd_q[RES_W-1:OP_W] <= wr_data;
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q <= RST_QUO;
            pr_q  <= RST_PR;
        end else if (dec.op == OP_MUL) begin
            pr_q <= prod;
        end else if (dec.op == OP_DIVZ) begin
            quo_q <= '1;
            pr_q  <= dvd_q;
        end else if (div_fin) begin
            quo_q <= div_quo;
            pr_q  <= RES_W'(div_rem);
        end
    end

    muldiv_rdmux #(.OP_W(OP_W)) rd_i (
        .addr    (addr),
        .quo     (quo_q),
        .pr      (pr_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk
    import muldiv_pkg::*;
#(
    parameter int OP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [OP_W-1:0]   wr_data,
    input logic              busy,
    input logic [OP_W-1:0]   mcand_q,
    input logic [2*OP_W-1:0] dvd_q,
    input logic [2*OP_W-1:0] quo_q,
    input logic [2*OP_W-1:0] pr_q
);
    localparam int RES_W = 2 * OP_W;
    localparam int RUN_W = $clog2(RES_W + 1) + 1;

    logic             dv_nz;
    logic             dv_z;
    logic             mul_wr;
    logic [RUN_W-1:0] run_q;

    assign dv_nz  = wr_en && (addr == OFS_DVSR) && (wr_data != '0);
    assign dv_z   = wr_en && (addr == OFS_DVSR) && (wr_data == '0);
    assign mul_wr = wr_en && (addr == OFS_MPLR);

    // Length of the current busy stretch, restarted by a divisor write
    always_ff @(posedge clk) begin
        if (rst || !busy || dv_nz) run_q <= '0;
        else                       run_q <= run_q + 1'b1;
    end

    a_r3_div_start: assert property (@(posedge clk) disable iff (rst)
        dv_nz |=> busy);

    a_r3_busy_len: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(RES_W));

    a_r4_zero_div: assert property (@(posedge clk) disable iff (rst)
        dv_z |=> (!busy && (quo_q == '1) && (pr_q == $past(dvd_q))));

    a_r2_product: assert property (@(posedge clk) disable iff (rst)
        mul_wr |=> (pr_q == RES_W'($past(mcand_q)) * RES_W'($past(wr_data))));

    a_r8_mul_abort: assert property (@(posedge clk) disable iff (rst)
        mul_wr |=> !busy);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_en) |=> (!busy || ($stable(quo_q) && $stable(pr_q))));

endmodule

bind muldiv_unit muldiv_chk #(.OP_W(OP_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .busy    (busy),
    .mcand_q (mcand_q),
    .dvd_q   (dvd_q),
    .quo_q   (quo_q),
    .pr_q    (pr_q)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
    import muldiv_pkg::*;

    localparam int  OP_W  = 8;
    localparam time CLK_P = 20;

    logic              clk     = 1'b0;
    logic              rst     = 1'b1;
    logic              wr_en   = 1'b0;
    logic [ADDR_W-1:0] addr    = '0;
    logic [7:0]        wr_data = '0;
    logic [7:0]        rd_data;
    logic              busy;

    always #(CLK_P/2) clk = ~clk;

    muldiv_unit #(.OP_W(OP_W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .busy    (busy)
    );

    typedef struct {
        bit                is_busy;
        logic [ADDR_W-1:0] a;
        logic [7:0]        exp;
        string             tag;
    } exp_t;

    exp_t sb[$];
    logic rd_req   = 1'b0;
    int   n_chk    = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    // Reference model state
    logic [7:0]  m_mc  = 8'hFF;
    logic [15:0] m_dvd = 16'hFFFF;
    logic [15:0] m_quo = 16'h0101;
    logic [15:0] m_pr  = 16'hFE01;

    // Monitor: compares outputs against queued expectations
    always begin
        @(negedge clk);
        #2;
        if (rd_req) begin
            exp_t       e;
            logic [7:0] act;
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: actual=empty expected=item");
            end else begin
                e   = sb.pop_front();
                act = e.is_busy ? {7'b0, busy} : rd_data;
                if (act !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: %s addr=%h actual=%h expected=%h",
                             e.tag, e.is_busy ? "busy" : "read", e.a, act, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1; rd_req = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            rd_req = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
        addr = a; rd_req = 1'b1;
        sb.push_back('{is_busy: 1'b0, a: a, exp: e, tag: tag});
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic chk_busy(input logic e, input string tag);
        rd_req = 1'b1;
        sb.push_back('{is_busy: 1'b1, a: addr, exp: {7'b0, e}, tag: tag});
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic chk_res(input string tag);
        chk_rd(OFS_QUO_LO, m_quo[7:0],  tag);
        chk_rd(OFS_QUO_HI, m_quo[15:8], tag);
        chk_rd(OFS_PR_LO,  m_pr[7:0],   tag);
        chk_rd(OFS_PR_HI,  m_pr[15:8],  tag);
    endtask

    task automatic set_mc(input logic [7:0] v);
        wr(OFS_MCAND, v); m_mc = v;
    endtask

    task automatic set_dvd(input logic [15:0] v);
        wr(OFS_DVD_LO, v[7:0]);
        wr(OFS_DVD_HI, v[15:8]);
        m_dvd = v;
    endtask

    task automatic do_mul(input logic [7:0] b, input string tag);
        wr(OFS_MPLR, b);
        m_pr = 16'(m_mc) * 16'(b);
        chk_res(tag);
    endtask

    task automatic wait_div(input string tag);
        for (int i = 0; i < 16; i++) chk_busy(1'b1, tag);
        chk_busy(1'b0, tag);
    endtask

    task automatic do_div(input logic [7:0] d, input string tag);
        wr(OFS_DVSR, d);
        if (d != 8'h00) begin
            wait_div("R3");
            m_quo = m_dvd / 16'(d);
            m_pr  = m_dvd % 16'(d);
        end else begin
            chk_busy(1'b0, "R4");
            m_quo = 16'hFFFF;
            m_pr  = m_dvd;
        end
        chk_res(tag);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state; R5: unmapped and write-only offsets read zero
        chk_busy(1'b0, "R1");
        chk_res("R1");
        chk_rd(5'h00, 8'h00, "R5");
        chk_rd(5'h10, 8'h00, "R5");
        chk_rd(OFS_MCAND, 8'h00, "R5");
        chk_rd(OFS_DVSR, 8'h00, "R5");
        // R1: reset multiplicand 0xFF and dividend 0xFFFF in use
        do_mul(8'h02, "R1");
        do_div(8'h10, "R1");

        // R2: multiply patterns
        set_mc(8'h00); do_mul(8'h37, "R2");
        set_mc(8'hFF); do_mul(8'hFF, "R2");
        set_mc(8'h12); do_mul(8'h34, "R2");
        set_mc(8'h80); do_mul(8'h01, "R2");
        // R6: multiplicand reused
        set_mc(8'h0D); do_mul(8'h03, "R6"); do_mul(8'h10, "R6");

        // R3: divide patterns, R6 dividend reuse
        set_dvd(16'h1234);
        do_div(8'h07, "R3");
        do_div(8'hFF, "R6");
        do_div(8'h01, "R6");
        set_dvd(16'h0005); do_div(8'h09, "R3");
        set_dvd(16'hFFFF); do_div(8'h80, "R3");

        // R4: divide by zero
        set_dvd(16'hBEEF); do_div(8'h00, "R4");

        // R9: dividend change during a running divide is not used by it
        set_dvd(16'h0100);
        wr(OFS_DVSR, 8'h03);
        wr(OFS_DVD_HI, 8'h20);
        for (int i = 0; i < 15; i++) chk_busy(1'b1, "R9");
        chk_busy(1'b0, "R9");
        m_quo = 16'h0100 / 16'd3;
        m_pr  = 16'h0100 % 16'd3;
        m_dvd = 16'h2000;
        chk_res("R9");
        do_div(8'h09, "R9");

        // R7: restart with current dividend and new divisor
        wr(OFS_DVSR, 8'h05);
        idle(3);
        wr(OFS_DVD_LO, 8'h0A);
        m_dvd = 16'h200A;
        wr(OFS_DVSR, 8'h07);
        wait_div("R7");
        m_quo = m_dvd / 16'd7;
        m_pr  = m_dvd % 16'd7;
        chk_res("R7");

        // R8: multiply abandons a running divide
        set_mc(8'h21);
        set_dvd(16'h4321);
        wr(OFS_DVSR, 8'h09);
        idle(3);
        wr(OFS_MPLR, 8'h05);
        m_pr = 16'(m_mc) * 16'd5;
        chk_busy(1'b0, "R8");
        chk_res("R8");
        idle(20);
        chk_res("R8");

        @(negedge clk);
        #5;
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule